// File: doc/BRIEF.md
# Serial Link Transmitter Reset Sequencer

This controller sits on the user side of a multi-gigabit serial transmit link that feeds a data converter. It brings the link out of reset in a fixed, handshake-gated order. Three resets are driven: an active-low link reset, an active-low configuration-bus reset and an active-high transceiver-reconfiguration reset. Each release waits for the matching event from outside: PLL lock, the end of configuration, the reset acknowledge from the link layer and its out-of-reset status. The controller then asks for a single SYSREF pulse if one is needed, and reports the link as up once both readiness inputs are high.

The out-of-reset status arrives from another clock domain, so it passes through a two-flop synchronizer before any decision uses it. Once the link has been released, a reset request at run time puts only the link reset back on. The controller then waits for the acknowledge and the status to show that the link layer really is in reset, and after that it runs the release part of the sequence again. Every wait has a programmable timeout. On expiry the controller sets a sticky error flag and starts again from full reset. A state code is brought out so that the order of the sequence can be observed.

Top module: `lnk_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, the outputs read: `seq_state`=0, `link_rst_n`=0, `cfgbus_rst_n`=0, `reconf_rst`=1, `sysref_req`=0, `link_up`=0, `seq_err`=0.
- R2: `cfgbus_rst_n`=0 or `reconf_rst`=1 occurs only while `link_rst_n`=0. The link reset may be asserted on its own.
- R3: State 0 always moves to state 1 (wait for lock) on the next clock. In state 1 all resets stay asserted. The first clock that samples `pll_locked`=1 moves to state 2 (configure), which releases `cfgbus_rst_n` and `reconf_rst`.
- R4: State 2 holds until `cfg_done` is sampled high, then moves to state 3 (wait for acknowledge).
- R5: In state 3, `link_rst_n` stays 0 until `rst_ack_n` is sampled 0. The controller then spends exactly one cycle in state 4 (release) with `link_rst_n`=1 and goes on to state 5 (wait for out-of-reset).
- R6: `out_of_reset` is synchronized by two flops. A change of level reaches a decision at the third rising edge that samples the new level.
- R7: When the synchronized status is 1 in state 5, the next state is 6 if `subclass1`=1 and `sysref_cont`=0, and 7 otherwise. State 6 lasts one cycle, and `sysref_req` is 1 only in state 6.
- R8: State 7 moves to state 8 (running) when `frame_ready` and `link_ready` are both sampled 1. `link_up` is 1 only in state 8, and state 8 falls back to state 7 when either input is 0.
- R9: In states 5 to 8, a `reset_req` sampled with `rst_ack_n`=1 moves the controller to state 9 (drain), where `link_rst_n`=0, `cfgbus_rst_n`=1 and `reconf_rst`=0. A request sampled with `rst_ack_n`=0 leaves the state unchanged.
- R10: State 9 moves to state 3 once `rst_ack_n`=0 and the synchronized status is 0.
- R11: In states 1, 2, 3, 5, 7 and 9, if the exit condition is still not met after `tmo_limit` cycles, the next state is 0 and `seq_err` is set. A `tmo_limit` of 0 disables the timeout. A run-time request and the normal exit both take priority over the timeout.
- R12: `seq_err` stays 1 until `rst_n` is asserted.
- R13: `seq_state` uses the codes 0 reset, 1 wait-lock, 2 configure, 3 wait-ack, 4 release, 5 wait-out-of-reset, 6 SYSREF, 7 wait-ready, 8 running, 9 drain, and never shows a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| reset_req | input | 1 | Run-time reset request |
| pll_locked | input | 1 | Core PLL lock |
| cfg_done | input | 1 | Configuration phase finished |
| rst_ack_n | input | 1 | Link-layer reset acknowledge, low when all channels are held in reset |
| out_of_reset | input | 1 | Link-layer out-of-reset status, asynchronous |
| subclass1 | input | 1 | Deterministic-latency subclass 1 mode |
| sysref_cont | input | 1 | SYSREF is supplied continuously |
| frame_ready | input | 1 | Frame layer ready |
| link_ready | input | 1 | Link layer ready |
| tmo_limit | input | TMO_W | Wait-state timeout in cycles, 0 disables it |
| link_rst_n | output | 1 | Link reset, active low |
| cfgbus_rst_n | output | 1 | Configuration-bus reset, active low |
| reconf_rst | output | 1 | Transceiver-reconfiguration reset, active high |
| sysref_req | output | 1 | One-cycle SYSREF request |
| link_up | output | 1 | Link operational |
| seq_err | output | 1 | Sticky timeout error |
| seq_state | output | 4 | Current state code |

## Verification
The assertions check, on every cycle, the rules that relate the outputs to each other and to the previous cycle. The side resets never appear without the link reset. The configuration-bus reset is released only after lock was sampled, and the link reset only after the acknowledge was sampled low. The SYSREF request lasts a single cycle. `link_up` follows both readiness inputs, the error flag never clears, and the state code stays in range. The order of the sequence, the two-cycle synchronizer latency, the SYSREF choice across the three mode settings, the request ignored while the acknowledge is low, the drain exit and the timeout with its disabled setting are shown only by the bench scenarios. In those scenarios a behavioural model tracks the state and every output on every clock.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_WLOCK   = 4'd1,
    ST_CONFIG  = 4'd2,
    ST_WACK    = 4'd3,
    ST_RELEASE = 4'd4,
    ST_WOOR    = 4'd5,
    ST_SYSREF  = 4'd6,
    ST_WREADY  = 4'd7,
    ST_RUN     = 4'd8,
    ST_DRAIN   = 4'd9
  } seq_st_e;

  // link reset held low in these states
  function automatic logic link_rst_active(input seq_st_e s);
    return !(s inside {ST_RELEASE, ST_WOOR, ST_SYSREF, ST_WREADY, ST_RUN});
  endfunction

  // configuration-bus reset held low only before configuration
  function automatic logic cfg_rst_active(input seq_st_e s);
    return (s == ST_RESET) || (s == ST_WLOCK);
  endfunction

  // reconfiguration reset follows the configuration-bus reset
  function automatic logic xcvr_rst_active(input seq_st_e s);
    return cfg_rst_active(s);
  endfunction

  // states guarded by the timeout counter
  function automatic logic is_timed(input seq_st_e s);
    return s inside {ST_WLOCK, ST_CONFIG, ST_WACK, ST_WOOR, ST_WREADY, ST_DRAIN};
  endfunction

  // states where a run-time reset request may be taken
  function automatic logic rtreq_window(input seq_st_e s);
    return s inside {ST_WOOR, ST_SYSREF, ST_WREADY, ST_RUN};
  endfunction

  // timeout fires on the last permitted cycle of a wait
  function automatic logic tmo_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[0] <= 1'b0;
          else        ff[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[i] <= 1'b0;
          else        ff[i] <= ff[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = ff[STAGES-1];
endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  import lbs_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = tmo_reached(32'(cnt_q), 32'(limit));
endmodule

// File: rtl/lbs_rst_drive.sv
module lbs_rst_drive (
  input  logic            clk,
  input  logic            rst_n,
  input  lbs_pkg::seq_st_e st_next,
  output logic            link_rst_n,
  output logic            cfgbus_rst_n,
  output logic            reconf_rst,
  output logic            sysref_req,
  output logic            link_up
);
  import lbs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_rst_n   <= 1'b0;
      cfgbus_rst_n <= 1'b0;
      reconf_rst   <= 1'b1;
      sysref_req   <= 1'b0;
      link_up      <= 1'b0;
    end else begin
      link_rst_n   <= !link_rst_active(st_next);
      cfgbus_rst_n <= !cfg_rst_active(st_next);
      reconf_rst   <= xcvr_rst_active(st_next);
      sysref_req   <= (st_next == ST_SYSREF);
      link_up      <= (st_next == ST_RUN);
    end
  end
endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq #(
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             pll_locked,
  input  logic             cfg_done,
  input  logic             rst_ack_n,
  input  logic             out_of_reset,
  input  logic             subclass1,
  input  logic             sysref_cont,
  input  logic             frame_ready,
  input  logic             link_ready,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             link_rst_n,
  output logic             cfgbus_rst_n,
  output logic             reconf_rst,
  output logic             sysref_req,
  output logic             link_up,
  output logic             seq_err,
  output logic [3:0]       seq_state
);
  import lbs_pkg::*;

  seq_st_e st_q, st_d;
  logic    oor_s;      // synchronized out-of-reset
  logic    tmo_hit;    // timer at its limit
  logic    st_chg;     // state changes on this edge
  logic    rtreq_ok;   // run-time request accepted
  logic    both_rdy;   // frame and link ready
  logic    need_pulse; // SYSREF pulse required
  logic    tmo_take;   // timeout forces full reset
  logic    err_q;

  lbs_sync #(.STAGES(SYNC_STAGES)) u_oor_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(out_of_reset),
    .q_sync (oor_s)
  );

  lbs_wait_timer #(.CW(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(st_chg),
    .limit  (tmo_limit),
    .expire (tmo_hit)
  );

  assign rtreq_ok   = reset_req && rst_ack_n && rtreq_window(st_q);
  assign both_rdy   = frame_ready && link_ready;
  assign need_pulse = subclass1 && !sysref_cont;

  always_comb begin
    st_d     = st_q;
    tmo_take = 1'b0;
    unique case (st_q)
      ST_RESET:   st_d = ST_WLOCK;
      ST_WLOCK:   if (pll_locked) st_d = ST_CONFIG;
                  else if (tmo_hit) tmo_take = 1'b1;
      ST_CONFIG:  if (cfg_done) st_d = ST_WACK;
                  else if (tmo_hit) tmo_take = 1'b1;
      ST_WACK:    if (!rst_ack_n) st_d = ST_RELEASE;
                  else if (tmo_hit) tmo_take = 1'b1;
      ST_RELEASE: st_d = ST_WOOR;
      ST_WOOR:    if (rtreq_ok) st_d = ST_DRAIN;
                  else if (oor_s) st_d = need_pulse ? ST_SYSREF : ST_WREADY;
                  else if (tmo_hit) tmo_take = 1'b1;
      ST_SYSREF:  st_d = rtreq_ok ? ST_DRAIN : ST_WREADY;
      ST_WREADY:  if (rtreq_ok) st_d = ST_DRAIN;
                  else if (both_rdy) st_d = ST_RUN;
                  else if (tmo_hit) tmo_take = 1'b1;
      ST_RUN:     if (rtreq_ok) st_d = ST_DRAIN;
                  else if (!both_rdy) st_d = ST_WREADY;
      ST_DRAIN:   if (!rst_ack_n && !oor_s) st_d = ST_WACK;
                  else if (tmo_hit) tmo_take = 1'b1;
      default:    st_d = ST_RESET;
    endcase
    if (tmo_take) st_d = ST_RESET;
  end

  assign st_chg = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RESET;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_q | tmo_take;
    end
  end

  lbs_rst_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_next     (st_d),
    .link_rst_n  (link_rst_n),
    .cfgbus_rst_n(cfgbus_rst_n),
    .reconf_rst  (reconf_rst),
    .sysref_req  (sysref_req),
    .link_up     (link_up)
  );

  assign seq_err   = err_q;
  assign seq_state = st_q;
endmodule

// File: rtl/lnk_bringup_seq_chk.sv
module lnk_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_locked,
  input logic       rst_ack_n,
  input logic       frame_ready,
  input logic       link_ready,
  input logic       link_rst_n,
  input logic       cfgbus_rst_n,
  input logic       reconf_rst,
  input logic       sysref_req,
  input logic       link_up,
  input logic       seq_err,
  input logic [3:0] seq_state
);
  // R2
  side_rst_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst_n |-> (cfgbus_rst_n && !reconf_rst));

  // R3
  cfg_release_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgbus_rst_n) |-> $past(pll_locked));

  // R5
  link_release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rst_n) |-> !$past(rst_ack_n));

  // R7
  sysref_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysref_req |=> !sysref_req);

  // R8
  link_up_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> $past(frame_ready && link_ready));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  // R13
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 4'd9);
endmodule

bind lnk_bringup_seq lnk_bringup_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pll_locked  (pll_locked),
  .rst_ack_n   (rst_ack_n),
  .frame_ready (frame_ready),
  .link_ready  (link_ready),
  .link_rst_n  (link_rst_n),
  .cfgbus_rst_n(cfgbus_rst_n),
  .reconf_rst  (reconf_rst),
  .sysref_req  (sysref_req),
  .link_up     (link_up),
  .seq_err     (seq_err),
  .seq_state   (seq_state)
);

// File: tb/lnk_bringup_seq_tb_top.sv
module lnk_bringup_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 0, pll_locked = 0, cfg_done = 0, rst_ack_n = 1, out_of_reset = 0;
  logic subclass1 = 1, sysref_cont = 0, frame_ready = 0, link_ready = 0;
  logic [15:0] tmo_limit = 16'd40;
  logic link_rst_n, cfgbus_rst_n, reconf_rst, sysref_req, link_up, seq_err;
  logic [3:0] seq_state;

  int checks = 0, errors = 0, sr_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lnk_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .pll_locked(pll_locked),
    .cfg_done(cfg_done), .rst_ack_n(rst_ack_n), .out_of_reset(out_of_reset),
    .subclass1(subclass1), .sysref_cont(sysref_cont), .frame_ready(frame_ready),
    .link_ready(link_ready), .tmo_limit(tmo_limit), .link_rst_n(link_rst_n),
    .cfgbus_rst_n(cfgbus_rst_n), .reconf_rst(reconf_rst), .sysref_req(sysref_req),
    .link_up(link_up), .seq_err(seq_err), .seq_state(seq_state)
  );

  // behavioural reference model
  int m_st = 0, m_cnt = 0;
  bit m_err = 0;
  int oq[$] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    int nx;
    bit ok_req, tmo, rdy;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_err = 0; oq = '{0, 0};
    end else begin
      nx = m_st;
      tmo = (tmo_limit != 0) && (m_cnt == int'(tmo_limit) - 1);
      ok_req = reset_req && rst_ack_n && (m_st >= 5) && (m_st <= 8);
      rdy = frame_ready && link_ready;
      case (m_st)
        0: nx = 1;
        1: nx = pll_locked ? 2 : (tmo ? -1 : 1);
        2: nx = cfg_done ? 3 : (tmo ? -1 : 2);
        3: nx = !rst_ack_n ? 4 : (tmo ? -1 : 3);
        4: nx = 5;
        5: nx = ok_req ? 9 : (oq[1] != 0) ? ((subclass1 && !sysref_cont) ? 6 : 7) : (tmo ? -1 : 5);
        6: nx = ok_req ? 9 : 7;
        7: nx = ok_req ? 9 : rdy ? 8 : (tmo ? -1 : 7);
        8: nx = ok_req ? 9 : (!rdy ? 7 : 8);
        9: nx = (!rst_ack_n && oq[1] == 0) ? 3 : (tmo ? -1 : 9);
        default: nx = 0;
      endcase
      if (nx < 0) begin nx = 0; m_err = 1; end
      if (nx != m_st) m_cnt = 0;
      else if (m_cnt < 65535) m_cnt++;
      m_st = nx;
      oq = '{int'(out_of_reset), oq[0]};
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R13", "state", int'(seq_state), m_st);
      chk("R5", "link_rst_n", int'(link_rst_n), (m_st >= 4 && m_st <= 8) ? 1 : 0);
      chk("R3", "cfgbus_rst_n", int'(cfgbus_rst_n), (m_st >= 2) ? 1 : 0);
      chk("R3", "reconf_rst", int'(reconf_rst), (m_st <= 1) ? 1 : 0);
      chk("R7", "sysref_req", int'(sysref_req), (m_st == 6) ? 1 : 0);
      chk("R8", "link_up", int'(link_up), (m_st == 8) ? 1 : 0);
      chk("R11", "seq_err", int'(seq_err), int'(m_err));
      if (sysref_req) sr_cnt++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // restart and run to the state after the out-of-reset decision
  task automatic bring_to_ready(input logic sc1, input logic cont);
    rst_n = 0; subclass1 = sc1; sysref_cont = cont;
    pll_locked = 1; rst_ack_n = 1; out_of_reset = 0; frame_ready = 0; link_ready = 0;
    tick(3);
    rst_n = 1; sr_cnt = 0;
    tick(2);
    cfg_done = 1; tick(1); cfg_done = 0;
    rst_ack_n = 0; tick(2);
    out_of_reset = 1; tick(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R1 reset values
    chk("R1", "state", int'(seq_state), 0);
    chk("R1", "link_rst_n", int'(link_rst_n), 0);
    chk("R1", "cfgbus_rst_n", int'(cfgbus_rst_n), 0);
    chk("R1", "reconf_rst", int'(reconf_rst), 1);
    chk("R1", "seq_err", int'(seq_err), 0);
    rst_n = 1;
    tick(1); chk("R3", "enter wait-lock", int'(seq_state), 1);
    tick(4); chk("R3", "hold without lock", int'(reconf_rst), 1);
    pll_locked = 1; tick(1);
    chk("R3", "configure", int'(seq_state), 2);
    chk("R3", "cfgbus released", int'(cfgbus_rst_n), 1);
    chk("R2", "link still in reset", int'(link_rst_n), 0);
    tick(3); chk("R4", "wait cfg_done", int'(seq_state), 2);
    cfg_done = 1; tick(1); cfg_done = 0;
    chk("R4", "wait-ack", int'(seq_state), 3);
    tick(3); chk("R5", "link held", int'(link_rst_n), 0);
    rst_ack_n = 0; tick(1);
    chk("R5", "release", int'(seq_state), 4);
    chk("R5", "link released", int'(link_rst_n), 1);
    tick(1); chk("R5", "wait-oor", int'(seq_state), 5);
    out_of_reset = 1; tick(2);
    chk("R6", "sync latency", int'(seq_state), 5);
    tick(1);
    chk("R7", "sysref state", int'(seq_state), 6);
    chk("R7", "sysref pulse", int'(sysref_req), 1);
    tick(1); chk("R7", "pulse ends", int'(sysref_req), 0);
    frame_ready = 1; tick(2);
    chk("R8", "one ready not enough", int'(seq_state), 7);
    link_ready = 1; tick(1);
    chk("R8", "running", int'(link_up), 1);
    frame_ready = 0; tick(1);
    chk("R8", "drop ready", int'(seq_state), 7);
    frame_ready = 1; tick(1);
    chk("R8", "running again", int'(seq_state), 8);
    // R9 request ignored while ack low
    reset_req = 1; tick(1); reset_req = 0;
    chk("R9", "ignored request", int'(seq_state), 8);
    chk("R9", "link untouched", int'(link_rst_n), 1);
    rst_ack_n = 1; reset_req = 1; tick(1); reset_req = 0;
    chk("R9", "drain", int'(seq_state), 9);
    chk("R9", "link reset only", int'(link_rst_n), 0);
    chk("R9", "cfgbus stays released", int'(cfgbus_rst_n), 1);
    rst_ack_n = 0; tick(2);
    chk("R10", "oor still high", int'(seq_state), 9);
    out_of_reset = 0; tick(2);
    chk("R10", "sync latency", int'(seq_state), 9);
    tick(1); chk("R10", "back to wait-ack", int'(seq_state), 3);
    tick(1); chk("R10", "release again", int'(seq_state), 4);
    // R7 mode variants
    bring_to_ready(1'b0, 1'b0);
    chk("R7", "subclass0 no pulse", sr_cnt, 0);
    chk("R7", "subclass0 state", int'(seq_state), 7);
    bring_to_ready(1'b1, 1'b1);
    chk("R7", "continuous no pulse", sr_cnt, 0);
    bring_to_ready(1'b1, 1'b0);
    chk("R7", "one pulse", sr_cnt, 1);
    // R11 timeout
    rst_n = 0; pll_locked = 0; tmo_limit = 16'd5; tick(2);
    rst_n = 1; tick(12);
    chk("R11", "timeout error", int'(seq_err), 1);
    pll_locked = 1; tick(3);
    chk("R12", "error sticky", int'(seq_err), 1);
    chk("R12", "progress", int'(seq_state), 2);
    rst_n = 0; pll_locked = 0; tmo_limit = 16'd0; tick(2);
    rst_n = 1; tick(60);
    chk("R11", "disabled timeout", int'(seq_err), 0);
    chk("R11", "still waiting", int'(seq_state), 1);
    finish_run();
  end
endmodule